// File: doc/BRIEF.md
# Regulator Enable Arbiter with Power-Good Fault Shutdown

This block decides, every clock, which of a bank of power regulators may run. Each regulator has an external enable pin and a bit in a software enable register. The top bit of that register selects how the two sources combine. In merge mode the register bits are OR-ed with the pins. In software-only mode the pins are ignored. Pulling the power-on input low wipes the enable register and drops every regulator.

Two qualifiers sit between the request and the regulator. The first is start-up gating. Each regulator has its own control bit that can make it wait until a comparator reports its output has discharged below threshold. Once released, it stays on for as long as its request holds. The second is a power-good fault timer. If any enabled regulator reports power-good low for a full window of clock cycles while the fault-shutdown arm bit is set, every regulator is forced off, and that state latches until power-on goes low or reset is applied. A registered interrupt-status output reports any enabled regulator whose power-good is low, whatever the arm bit says.

Top module: `reg_en_arbiter`

## Requirements
- R1: With enable-register bit N (the mode bit, bit 7 by default) at 0, each regulator i is requested when register bit i OR pin i is 1. Its enable follows one clock after the request appears.
- R2: With the mode bit at 1, the pins have no effect, and regulator i is requested only by register bit i.
- R3: While `pwr_on` is 0, the enable register reads 0 on the next clock and every enable is 0. This clear takes priority over a register write in the same cycle.
- R4: With control bit N (the arm bit, bit 7 by default) at 1, a power-good fault that lasts `FAULT_CYCLES` consecutive clocks raises `fault_sd` on the clock that completes the window. It also drops all enables on that same clock. Any clock without a fault restarts the count.
- R5: With the arm bit at 0, a fault of any length never raises `fault_sd` and leaves the enables on.
- R6: If control bit i is 1, regulator i does not turn on while `below_thr[i]` is 0. It turns on one clock after its request and `below_thr[i]` are both 1. If control bit i is 0, it starts without waiting.
- R7: Once regulator i is on, it stays on while its request holds, regardless of `below_thr[i]`. It turns off one clock after its request drops.
- R8: `irq_pg` is 1 one clock after any enabled regulator has `pgood` at 0. A regulator that is not enabled has no effect on it. The arm bit does not change it.
- R9: `fault_sd` latches. While it is 1 all enables stay 0, even after power-good recovers. It clears only on `pwr_on` low or reset, and a `pwr_on` low in the cycle that would complete the window prevents the shutdown.
- R10: Synchronous reset `rst` clears the enable register, all enables, `fault_sd` and `irq_pg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on | input | 1 | Global power-on; low clears register and shutdown |
| en_pin | input | N_REG | External enable pins |
| sw_we | input | 1 | Enable-register write strobe |
| sw_wdata | input | N_REG+1 | Enable-register write data; top bit is the mode bit |
| sw_rdata | output | N_REG+1 | Enable-register contents |
| ctl | input | N_REG+1 | Control: bit i start-wait, top bit shutdown arm |
| pgood | input | N_REG | Per-regulator power-good flags |
| below_thr | input | N_REG | Per-regulator output-discharged flags |
| reg_en | output | N_REG | Final regulator enables |
| fault_sd | output | 1 | Latched power-good fault shutdown |
| irq_pg | output | 1 | Power-good fault status for interrupt |

## Verification
A power-on clear can land on the same clock edge that would complete the fault window, or on the same edge as a register write. The bench provokes the first by holding a fault for one clock less than the window and then dropping `pwr_on` for the completing clock. It expects `fault_sd` to stay 0 with the enables and register cleared. For the second, it drives a write of all ones together with `pwr_on` low and expects the register to read 0. Each expected outcome goes into the scoreboard queue and is compared on the falling edge after the deciding clock.

// File: rtl/reg_en_pkg.sv
package reg_en_pkg;
  typedef enum logic {
    MODE_MERGE   = 1'b0,
    MODE_SW_ONLY = 1'b1
  } req_mode_e;
endpackage

// File: rtl/reg_en_swreg.sv
module reg_en_swreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwr_on,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || !pwr_on) q <= '0;
    else if (we)        q <= wdata;
  end

  p_pwr_clear_r3: assert property (@(posedge clk) disable iff (rst)
    !pwr_on |=> (q == '0));
endmodule

// File: rtl/reg_en_start_gate.sv
module reg_en_start_gate (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic req,
  input  logic wait_en,
  input  logic below,
  output logic active
);
  always_ff @(posedge clk) begin
    if (rst || clr)                       active <= 1'b0;
    else if (!req)                        active <= 1'b0;
    else if (!active && (!wait_en || below)) active <= 1'b1;
  end

  p_wait_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (!active && wait_en && !below) |=> !active);
  p_hold_on_r7: assert property (@(posedge clk) disable iff (rst)
    (active && req && !clr) |=> active);
endmodule

// File: rtl/reg_en_pg_fault.sv
module reg_en_pg_fault #(
  parameter int N_REG       = 7,
  parameter int FAULT_CYCLES = 3_500_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_on,
  input  logic             arm,
  input  logic [N_REG-1:0] active,
  input  logic [N_REG-1:0] pgood,
  output logic             sd_set,
  output logic             sd_q,
  output logic             irq_q
);
  localparam int CW = $clog2(FAULT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FAULT_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          fault_now;

  assign fault_now = |(active & ~pgood);
  assign sd_set    = fault_now && arm && (cnt == LAST) && pwr_on && !sd_q;

  always_ff @(posedge clk) begin
    if (rst || !pwr_on) begin
      cnt   <= '0;
      sd_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (!fault_now)       cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
      if (sd_set) sd_q <= 1'b1;
      irq_q <= fault_now;
    end
  end

  p_sd_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (sd_q && pwr_on) |=> sd_q);
  p_no_sd_unarmed_r5: assert property (@(posedge clk) disable iff (rst)
    (!arm && !sd_q) |=> !sd_q);
  p_irq_needs_active_r8: assert property (@(posedge clk) disable iff (rst)
    (pwr_on && !(|active)) |=> !irq_q);
endmodule

// File: rtl/reg_en_arbiter.sv
module reg_en_arbiter #(
  parameter int N_REG        = 7,
  parameter int FAULT_CYCLES = 3_500_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_on,
  input  logic [N_REG-1:0] en_pin,
  input  logic             sw_we,
  input  logic [N_REG:0]   sw_wdata,
  output logic [N_REG:0]   sw_rdata,
  input  logic [N_REG:0]   ctl,
  input  logic [N_REG-1:0] pgood,
  input  logic [N_REG-1:0] below_thr,
  output logic [N_REG-1:0] reg_en,
  output logic             fault_sd,
  output logic             irq_pg
);
  import reg_en_pkg::*;
  localparam int RW = N_REG + 1;

  logic [RW-1:0]    swq;
  logic [N_REG-1:0] req;
  logic [N_REG-1:0] active;
  logic             sd_set, sd_q, irq_q, clr;
  req_mode_e        mode;

  reg_en_swreg #(.W(RW)) u_swreg (
    .clk(clk), .rst(rst), .pwr_on(pwr_on),
    .we(sw_we), .wdata(sw_wdata), .q(swq)
  );

  assign mode = req_mode_e'(swq[N_REG]);
  assign req  = (mode == MODE_SW_ONLY) ? swq[N_REG-1:0]
                                       : (swq[N_REG-1:0] | en_pin);
  assign clr  = !pwr_on || sd_q || sd_set;

  for (genvar i = 0; i < N_REG; i++) begin : g_gate
    reg_en_start_gate u_gate (
      .clk(clk), .rst(rst), .clr(clr), .req(req[i]),
      .wait_en(ctl[i]), .below(below_thr[i]), .active(active[i])
    );
  end

  reg_en_pg_fault #(.N_REG(N_REG), .FAULT_CYCLES(FAULT_CYCLES)) u_fault (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .arm(ctl[N_REG]),
    .active(active), .pgood(pgood),
    .sd_set(sd_set), .sd_q(sd_q), .irq_q(irq_q)
  );

  assign sw_rdata = swq;
  assign reg_en   = active;
  assign fault_sd = sd_q;
  assign irq_pg   = irq_q;

  p_sd_blocks_en_r9: assert property (@(posedge clk) disable iff (rst)
    fault_sd |-> (reg_en == '0));
  p_pwr_off_en_r3: assert property (@(posedge clk) disable iff (rst)
    !pwr_on |=> (reg_en == '0) && !fault_sd);
  p_reset_r10: assert property (@(posedge clk)
    rst |=> (reg_en == '0) && !fault_sd && !irq_pg && (sw_rdata == '0));
endmodule

// File: tb/sim_reg_en_arbiter.sv
module sim_reg_en_arbiter;
  localparam int N = 7;
  localparam int FC = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst, pwr_on, sw_we;
  logic [N-1:0] en_pin, pgood, below_thr, reg_en;
  logic [N:0]   sw_wdata, sw_rdata, ctl;
  logic         fault_sd, irq_pg;

  reg_en_arbiter #(.N_REG(N), .FAULT_CYCLES(FC)) u0 (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .en_pin(en_pin),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .ctl(ctl),
    .pgood(pgood), .below_thr(below_thr), .reg_en(reg_en),
    .fault_sd(fault_sd), .irq_pg(irq_pg)
  );

  typedef struct {
    logic [N-1:0] en;
    logic         sd;
    logic         irq;
    logic [N:0]   rd;
    string        tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic [N-1:0] en, input logic sd,
                            input logic irq, input logic [N:0] rd,
                            input string tag);
    exp_t e;
    e.en = en; e.sd = sd; e.irq = irq; e.rd = rd; e.tag = tag;
    sb.push_back(e);
    wait (sb.size() == 0);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (sb.size() != 0);
      e = sb[0];
      checks++;
      if (reg_en !== e.en || fault_sd !== e.sd || irq_pg !== e.irq || sw_rdata !== e.rd) begin
        errors++;
        $display("FAIL %s: en=%h sd=%b irq=%b rd=%h expected en=%h sd=%b irq=%b rd=%h",
                 e.tag, reg_en, fault_sd, irq_pg, sw_rdata, e.en, e.sd, e.irq, e.rd);
      end
      void'(sb.pop_front());
    end
  end

  task automatic wr(input logic [N:0] d);
    sw_we = 1'b1; sw_wdata = d; cyc(1); sw_we = 1'b0;
  endtask

  initial begin
    fork
      begin : driver
        rst = 1; pwr_on = 1; sw_we = 0; sw_wdata = '0; ctl = '0;
        en_pin = '0; pgood = '1; below_thr = '0;
        cyc(3); rst = 0;
        expect_out('0, 0, 0, '0, "R10 reset state");
        // R1 merge mode
        en_pin = 7'h05; cyc(1);
        expect_out(7'h05, 0, 0, 8'h00, "R1 pins only");
        wr(8'h12);
        expect_out(7'h05, 0, 0, 8'h12, "R1 write latency");
        cyc(1);
        expect_out(7'h17, 0, 0, 8'h12, "R1 pins OR register");
        // R2 software-only mode
        wr(8'h92); en_pin = 7'h7F; cyc(1);
        expect_out(7'h12, 0, 0, 8'h92, "R2 pins ignored");
        cyc(3);
        expect_out(7'h12, 0, 0, 8'h92, "R2 pins ignored held");
        // R3 power-on clear beats write
        pwr_on = 0; sw_we = 1; sw_wdata = 8'hFF; cyc(1);
        expect_out('0, 0, 0, 8'h00, "R3 clear over write");
        sw_we = 0; pwr_on = 1; cyc(1);
        expect_out(7'h7F, 0, 0, 8'h00, "R3 register cleared, pins merge");
        // R6/R7 start gating
        en_pin = '0; cyc(1);
        expect_out('0, 0, 0, 8'h00, "R7 off when request drops");
        ctl = 8'h01; en_pin = 7'h01; below_thr = '0; cyc(3);
        expect_out('0, 0, 0, 8'h00, "R6 waits for discharge");
        below_thr = 7'h01; cyc(1);
        expect_out(7'h01, 0, 0, 8'h00, "R6 released by below flag");
        below_thr = '0; cyc(3);
        expect_out(7'h01, 0, 0, 8'h00, "R7 stays on after release");
        en_pin = 7'h03; cyc(1);
        expect_out(7'h03, 0, 0, 8'h00, "R6 no-wait regulator starts");
        en_pin = '0; cyc(1);
        expect_out('0, 0, 0, 8'h00, "R7 drop request");
        en_pin = 7'h01; cyc(2);
        expect_out('0, 0, 0, 8'h00, "R6 waits again after restart");
        // R8/R5 irq and unarmed fault
        ctl = 8'h00; cyc(1);
        expect_out(7'h01, 0, 0, 8'h00, "R6 starts with wait cleared");
        pgood = 7'h7E; cyc(1);
        expect_out(7'h01, 0, 1, 8'h00, "R8 irq on enabled fault");
        cyc(20);
        expect_out(7'h01, 0, 1, 8'h00, "R5 unarmed no shutdown");
        pgood = 7'h7D; cyc(1);
        expect_out(7'h01, 0, 0, 8'h00, "R8 disabled regulator ignored");
        // R4 armed shutdown
        ctl = 8'h80; pgood = 7'h7E; cyc(FC - 1);
        expect_out(7'h01, 0, 1, 8'h00, "R4 one short of window");
        cyc(1);
        expect_out('0, 1, 1, 8'h00, "R4 shutdown at window");
        cyc(1);
        expect_out('0, 1, 0, 8'h00, "R9 irq follows dropped enables");
        pgood = '1; cyc(3);
        expect_out('0, 1, 0, 8'h00, "R9 latched after recovery");
        wr(8'h04); cyc(1);
        expect_out('0, 1, 0, 8'h04, "R9 latched despite write");
        pwr_on = 0; cyc(1);
        expect_out('0, 0, 0, 8'h00, "R9 cleared by power-on low");
        pwr_on = 1; cyc(1);
        expect_out(7'h01, 0, 0, 8'h00, "R9 enables return");
        // R4 interrupted fault restarts count
        pgood = 7'h7E; cyc(5); pgood = '1; cyc(1); pgood = 7'h7E; cyc(FC - 1);
        expect_out(7'h01, 0, 1, 8'h00, "R4 interrupted count restarts");
        cyc(1);
        expect_out('0, 1, 1, 8'h00, "R4 fires after full window");
        // Collision: power-on low on completing edge
        pwr_on = 0; pgood = '1; cyc(1); pwr_on = 1; cyc(1);
        expect_out(7'h01, 0, 0, 8'h00, "R9 recovered");
        pgood = 7'h7E; cyc(FC - 1); pwr_on = 0; cyc(1);
        expect_out('0, 0, 0, 8'h00, "R9 power-on low beats shutdown");
        pwr_on = 1; pgood = '1; cyc(1);
        expect_out(7'h01, 0, 0, 8'h00, "R3 normal after collision");
        rst = 1; cyc(1);
        expect_out('0, 0, 0, 8'h00, "R10 mid-run reset");
        rst = 0;
        done = 1;
      end
      begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: run hung, actual=running expected=done");
        end
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule